// File: doc/BRIEF.md
# Device Image Checksum Accumulator

This block reduces a stream of device-image words to a 16-bit checksum. A fetch engine outside the block reads the image and hands it over one word per cycle. Each word comes with a valid strobe and a two-bit kind tag. The image is made of the program words, one configuration word and four identification words. A one-cycle `start` pulse opens a computation. A one-cycle `done` pulse closes it once the expected number of words has arrived. That number is `PROG_WORDS + 5`, and `PROG_WORDS` is 1024, 2048 or 4096 as chosen by the `SIZE_SEL` parameter.

The formula depends on the protection flag, which is bit 13 of the configuration word; a value of 0 means protected. With protection off, the checksum is the sum of all program words plus the configuration word masked with 0x21FF. With protection on, the program words play no part. The checksum is then the masked configuration word plus a 16-bit value built from the low nibble of each identification word. The first identification word in the stream supplies the top nibble. The configuration word may arrive anywhere in the stream, so the block keeps a program sum, an identifier nibble register and the configuration word separately, and picks the result from them at the end.

The controller has four states. `ST_IDLE` is the state after reset. `ST_COLLECT` is entered on start, from any state. `ST_FINISH` is entered from collection when the final expected word is taken, and lasts one cycle with `done` high. `ST_HOLD` follows finish unconditionally and keeps the result until the next start.

Top module: `image_checksum`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `checksum` is 0x0000.
- R2: With configuration bit 13 equal to 1, `checksum` equals the sum, modulo 2^16, of every program word (kind 2'b00), plus the configuration word (kind 2'b01) ANDed with 0x21FF.
- R3: With configuration bit 13 equal to 0, `checksum` equals the masked configuration word plus a packed value made from bits 3:0 of the four identification words (kind 2'b10). The first identification word supplies bits 15:12 and the last supplies bits 3:0.
- R4: When protection is on, the values of the program words have no effect on `checksum`.
- R5: With protection off and every word at 0x3FFF, the result is 0x1DFF for 1K program words, 0x19FF for 2K and 0x11FF for 4K.
- R6: `done` is high for exactly one cycle, namely the cycle after the one in which the `PROG_WORDS+5`-th counted word is presented. `busy` is high from the cycle after `start` until that last word has been taken.
- R7: Once `done` has pulsed, `checksum` stays unchanged until the next `start`, and words presented while `busy` is low are ignored.
- R8: `start` clears all accumulated state and restarts collection from any state, including part-way through a stream. A word presented in the same cycle as `start` is discarded.
- R9: Words tagged with the reserved kind 2'b11 are neither summed nor counted.
- R10: The position of the configuration word within the stream, and the interleaving of program and identification words, do not change the result. Only the relative order of the identification words matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a new computation |
| word_valid | input | 1 | Marks `word_kind` and `word_data` as valid this cycle |
| word_kind | input | 2 | 00 program, 01 configuration, 10 identification, 11 reserved |
| word_data | input | 14 | Image word |
| busy | output | 1 | High while words are being collected |
| done | output | 1 | One-cycle pulse when the checksum is final |
| checksum | output | 16 | Current checksum, final from `done` until the next `start` |

## Verification
The assertions check the handshake on every cycle: `done` never lasts longer than one cycle, it only follows a cycle of collection, collection only ends through `done`, a start always leads into collection, and the checksum does not move outside collection. The numeric content of the checksum can only be shown by the bench's scenarios. These cover the modular wrap, both protection formulas, the blank-image value, insensitivity to program words and to the position of the configuration word, and dropping of reserved words and of a word that coincides with start.

// File: rtl/imgck_pkg.sv
package imgck_pkg;
    typedef enum logic [1:0] {
        KIND_PROG = 2'b00,
        KIND_CFG  = 2'b01,
        KIND_ID   = 2'b10,
        KIND_RSV  = 2'b11
    } word_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_FINISH,
        ST_HOLD
    } ck_state_t;

    localparam int unsigned WORD_W    = 14;
    localparam int unsigned SUM_W     = 16;
    localparam int unsigned ID_COUNT  = 4;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned PROT_BIT  = 13;
    localparam logic [SUM_W-1:0] CFG_MASK = 16'h21FF;
endpackage

// File: rtl/imgck_ctrl.sv
module imgck_ctrl #(
    parameter int unsigned TOTAL = 1029
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic counted,
    output logic busy,
    output logic done,
    output logic take
);
    import imgck_pkg::*;

    localparam int unsigned CW = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    ck_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_COLLECT;
            ST_COLLECT: if (start) state_d = ST_COLLECT;
                        else if (counted && cnt_q == LAST) state_d = ST_FINISH;
            ST_FINISH:  state_d = start ? ST_COLLECT : ST_HOLD;
            ST_HOLD:    if (start) state_d = ST_COLLECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)     cnt_q <= '0;
            else if (take) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy = (state_q == ST_COLLECT);
        done = (state_q == ST_FINISH);
        take = busy && counted && !start;
    end
endmodule

// File: rtl/imgck_prog_acc.sv
module imgck_prog_acc #(
    parameter int unsigned DW = 14,
    parameter int unsigned SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          add_en,
    input  logic [DW-1:0] word,
    output logic [SW-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum <= '0;
        else if (clear)  sum <= '0;
        else if (add_en) sum <= sum + SW'(word);
    end
endmodule

// File: rtl/imgck_id_pack.sv
module imgck_id_pack #(
    parameter int unsigned NW = 4,
    parameter int unsigned SLOTS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic [NW-1:0]       nib,
    output logic [NW*SLOTS-1:0] packed_val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        packed_val <= '0;
        else if (clear)    packed_val <= '0;
        else if (shift_en) packed_val <= {packed_val[NW*(SLOTS-1)-1:0], nib};
    end
endmodule

// File: rtl/image_checksum.sv
module image_checksum #(
    parameter int unsigned SIZE_SEL = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        word_valid,
    input  logic [1:0]  word_kind,
    input  logic [13:0] word_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] checksum
);
    import imgck_pkg::*;

    localparam int unsigned PROG_WORDS = 1024 << SIZE_SEL;
    localparam int unsigned TOTAL      = PROG_WORDS + 1 + ID_COUNT;

    logic counted, take;
    logic [SUM_W-1:0]        prog_sum;
    logic [NIB_W*ID_COUNT-1:0] id_val;
    logic [WORD_W-1:0]       cfg_q;
    logic                    protect;
    word_kind_t              kind;

    assign kind    = word_kind_t'(word_kind);
    assign counted = word_valid && (kind != KIND_RSV);

    imgck_ctrl #(.TOTAL(TOTAL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .counted(counted),
        .busy(busy), .done(done), .take(take)
    );

    imgck_prog_acc #(.DW(WORD_W), .SW(SUM_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .add_en(take && kind == KIND_PROG), .word(word_data), .sum(prog_sum)
    );

    imgck_id_pack #(.NW(NIB_W), .SLOTS(ID_COUNT)) u_ids (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .shift_en(take && kind == KIND_ID), .nib(word_data[NIB_W-1:0]),
        .packed_val(id_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cfg_q <= '0;
        else if (start)                      cfg_q <= '0;
        else if (take && kind == KIND_CFG)   cfg_q <= word_data;
    end

    assign protect  = ~cfg_q[PROT_BIT];
    assign checksum = (SUM_W'(cfg_q) & CFG_MASK) + (protect ? id_val : prog_sum);
endmodule

// File: rtl/imgck_checker.sv
module imgck_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [15:0] checksum
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R6
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_START_COLLECTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(checksum)); // R7
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R6
endmodule

bind image_checksum imgck_checker chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .checksum(checksum)
);

// File: tb/image_checksum_test.sv
module image_checksum_test;
    localparam int NW = 1024;
    localparam int NV = 6;

    localparam logic [13:0] V_CFG [NV] = '{14'h3FFF, 14'h3FFF, 14'h1FFF, 14'h1FFF, 14'h0A5C, 14'h3ABC};
    localparam logic [13:0] V_BASE[NV] = '{14'h3FFF, 14'h0001, 14'h1555, 14'h2AAA, 14'h0F0F, 14'h3FF0};
    localparam logic [13:0] V_STEP[NV] = '{14'h0000, 14'h0123, 14'h0007, 14'h0033, 14'h0101, 14'h3FFF};
    localparam logic [13:0] V_ID0 [NV] = '{14'h3FFF, 14'h0000, 14'h0001, 14'h0001, 14'h3FF9, 14'h0005};
    localparam logic [13:0] V_ID1 [NV] = '{14'h3FFF, 14'h0000, 14'h0002, 14'h0002, 14'h0C0A, 14'h0006};
    localparam logic [13:0] V_ID2 [NV] = '{14'h3FFF, 14'h0000, 14'h0003, 14'h0003, 14'h0000, 14'h0007};
    localparam logic [13:0] V_ID3 [NV] = '{14'h3FFF, 14'h0000, 14'h0004, 14'h0004, 14'h1237, 14'h0008};
    localparam int          V_ORD [NV] = '{0, 1, 0, 2, 1, 2};

    logic clk = 0, rst_n = 0, start = 0, word_valid = 0;
    logic [1:0] word_kind = 0;
    logic [13:0] word_data = 0;
    logic busy, done;
    logic [15:0] checksum;
    int total = 0, bad = 0;
    bit finished = 0;

    image_checksum uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
        .word_kind(word_kind), .word_data(word_data),
        .busy(busy), .done(done), .checksum(checksum)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] pword(input logic [13:0] b, input logic [13:0] s, input int i);
        return 14'(b + 14'(i) * s);
    endfunction

    function automatic logic [15:0] model(input int v);
        logic [15:0] s = 16'h0;
        logic [15:0] m = {2'b00, V_CFG[v]} & 16'h21FF;
        if (!V_CFG[v][13])
            return m + {V_ID0[v][3:0], V_ID1[v][3:0], V_ID2[v][3:0], V_ID3[v][3:0]};
        for (int i = 0; i < NW; i++) s = s + {2'b00, pword(V_BASE[v], V_STEP[v], i)};
        return s + m;
    endfunction

    task automatic put(input logic [1:0] k, input logic [13:0] d);
        @(negedge clk);
        start = 0; word_valid = 1; word_kind = k; word_data = d;
    endtask

    task automatic begin_run(input bit with_word);
        @(negedge clk);
        start = 1; word_valid = with_word; word_kind = 2'b10; word_data = 14'h000F;
    endtask

    task automatic send_ids(input int v);
        put(2'b10, V_ID0[v]); put(2'b10, V_ID1[v]);
        put(2'b10, V_ID2[v]); put(2'b10, V_ID3[v]);
    endtask

    task automatic send_prog(input int v, input int lo, input int hi);
        for (int i = lo; i < hi; i++) put(2'b00, pword(V_BASE[v], V_STEP[v], i));
    endtask

    // Streams vector v; the final word is left on the bus at return.
    task automatic send_image(input int v);
        case (V_ORD[v])
            0: begin send_prog(v, 0, NW); put(2'b01, V_CFG[v]); send_ids(v); end
            1: begin put(2'b01, V_CFG[v]); send_ids(v); send_prog(v, 0, NW); end
            default: begin
                send_prog(v, 0, NW/2);
                put(2'b11, 14'h1234);           // R9 reserved word
                put(2'b10, V_ID0[v]); put(2'b10, V_ID1[v]);
                put(2'b01, V_CFG[v]);
                send_prog(v, NW/2, NW - 1);
                put(2'b11, 14'h3FFF);           // R9 reserved word
                put(2'b10, V_ID2[v]); put(2'b10, V_ID3[v]);
                send_prog(v, NW - 1, NW);
            end
        endcase
    endtask

    task automatic finish_and_check(input string req, input logic [15:0] exp);
        logic [15:0] held;
        check("R6 busy before last word taken", {15'b0, busy}, 16'h1);
        check("R6 done not early", {15'b0, done}, 16'h0);
        @(negedge clk);
        word_valid = 0;
        check("R6 done pulse", {15'b0, done}, 16'h1);
        check(req, checksum, exp);
        held = checksum;
        word_valid = 1; word_kind = 2'b00; word_data = 14'h2222;   // R7 ignored
        @(negedge clk);
        word_kind = 2'b01; word_data = 14'h0000;                  // R7 ignored
        check("R6 done single cycle", {15'b0, done}, 16'h0);
        @(negedge clk);
        word_valid = 0;
        check("R7 result held", checksum, held);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", {15'b0, busy}, 16'h0);
        check("R1 reset done", {15'b0, done}, 16'h0);
        check("R1 reset checksum", checksum, 16'h0000);
        @(negedge clk) rst_n = 1;

        // R1: stray words without start are ignored
        put(2'b10, 14'h000F); put(2'b01, 14'h0000);
        @(negedge clk) word_valid = 0;
        check("R1 idle ignores words", checksum, 16'h0000);
        check("R1 idle not busy", {15'b0, busy}, 16'h0);

        for (int v = 0; v < NV; v++) begin
            begin_run(1'b0);
            send_image(v);
            finish_and_check($sformatf("R2 R3 R10 vector %0d", v), model(v));
            if (v == 0) check("R5 blank 1K", checksum, 16'h1DFF);
            if (v == 2) check("R3 packed ids", checksum, 16'h1433);
            if (v == 3) check("R4 program words ignored", checksum, 16'h1433);
            if (v == 4) check("R3 low nibbles only", checksum, 16'h9A63);
        end

        // R8: restart part-way through a stream
        begin_run(1'b0);
        put(2'b01, 14'h3FFF);
        send_prog(1, 0, 300);
        put(2'b10, 14'h000E);
        begin_run(1'b1);    // R8: word presented with start is discarded
        send_image(2);
        finish_and_check("R8 restart clears", 16'h1433);

        // R9: reserved words do not count toward done
        begin_run(1'b0);
        send_image(3);
        finish_and_check("R9 reserved not counted", 16'h1433);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule